// File: doc/BRIEF.md
# Dual-Standard Receiver Power Sequencer

This block owns five control lines that power, reset and select between two receiver front ends: one for a terrestrial broadcast standard and one for a mobile standard. A one-cycle start strobe with a two-bit mode request launches a sequence. The sequence first shuts down the front end that is not wanted. It then enables power on the wanted side, releases that side's reset, and switches the transport select last. A fixed wait separates each of these steps from the next.

The wait is counted in milliseconds. A prescaler, sized from the clock-frequency parameter, makes one tick per millisecond, and a second counter accumulates the ticks for each gap. A mode request that names neither standard is a standby request. It clears every line at once and needs no wait. While a sequence runs, the block sets a busy flag and drops any further start strobe. When the sequence ends, a done flag pulses for one cycle. The control pins are plain levels. No data stream crosses the block, so no valid/ready handshake is needed.

Top module: `rx_power_sequencer`

## Requirements
- R1: A synchronous active-high reset clears all five lines, busy and done in the cycle after the reset edge. The block then waits idle for a start strobe.
- R2: Line vector bit 0 is the transport select (1 = terrestrial path, 0 = mobile path). Bit 1 is the terrestrial active-low reset and bit 2 the terrestrial power enable. Bit 3 is the mobile active-low reset and bit 4 the mobile power enable. Mode code 2'b01 requests mobile and 2'b10 requests terrestrial.
- R3: On a mobile request, the edge that samples the strobe clears bits 1 and 2 together. One gap later bit 4 rises. One further gap later bit 3 rises. After a third gap bit 0 is cleared, leaving 5'b11000 when starting from all-zero.
- R4: On a terrestrial request, the edge that samples the strobe clears bits 3 and 4 together. One gap later bit 2 rises. One further gap later bit 1 rises. After a third gap bit 0 is set, leaving 5'b00111 from any start.
- R5: Each gap lasts exactly (CLK_HZ/1000)*WAIT_MS cycles between consecutive line updates, so a two-standard sequence keeps busy high for three gaps in total.
- R6: On either side, the active-low reset line is never high while that side's power enable is low.
- R7: Mode codes 2'b00 and 2'b11 are standby. The edge that samples the strobe clears all five lines, busy never rises, and done pulses in the next cycle.
- R8: Busy is high from the cycle after the accepted strobe until the final line update. Done is high for exactly one cycle, the one that follows the final update, and never together with busy.
- R9: A start strobe that arrives while busy or done is high is ignored, and the running sequence completes unchanged.
- R10: The transport select changes only at the final step of a sequence, so when switching from terrestrial to mobile it stays 1 while the mobile side powers up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_mode | input | 2 | Requested mode, sampled with start |
| start | input | 1 | One-cycle request strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ctl_lines | output | 5 | Front-end control lines (bit map in R2) |

## Verification
The checker watches several properties on every cycle. It checks the power-before-reset ordering on both sides, that busy and done never overlap, and that done lasts a single cycle. It clears lines after reset. It also uses its own cycle counter to confirm that every update inside a sequence lands exactly one gap after the previous one. Some behaviour only shows up in the bench's scenarios: the exact final line patterns, the mirrored order of the steps, the late switch of the transport select when changing standards, how codes 00 and 11 act as standby, and whether strobes sent in mid-sequence are dropped. The bench covers these by comparing against its behavioural model on every clock.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

  localparam int NLINES = 5;

  typedef logic [NLINES-1:0] lines_t;

  localparam logic [1:0] MODE_MOBILE = 2'b01;
  localparam logic [1:0] MODE_TERR   = 2'b10;

  // Line positions (bit index in the control vector)
  localparam lines_t BIT_TSEL   = 5'b00001;
  localparam lines_t BIT_T_RSTN = 5'b00010;
  localparam lines_t BIT_T_PWR  = 5'b00100;
  localparam lines_t BIT_M_RSTN = 5'b01000;
  localparam lines_t BIT_M_PWR  = 5'b10000;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GAP1,
    SQ_GAP2,
    SQ_GAP3,
    SQ_FIN
  } sq_state_t;

  // Power-enable bit of the side a mode selects
  function automatic lines_t own_pwr(input logic [1:0] mode);
    return (mode == MODE_MOBILE) ? BIT_M_PWR : BIT_T_PWR;
  endfunction

  // Reset bit of the side a mode selects
  function automatic lines_t own_rstn(input logic [1:0] mode);
    return (mode == MODE_MOBILE) ? BIT_M_RSTN : BIT_T_RSTN;
  endfunction

  // Both control bits of the side a mode turns off
  function automatic lines_t other_side(input logic [1:0] mode);
    return (mode == MODE_MOBILE) ? (BIT_T_PWR | BIT_T_RSTN)
                                 : (BIT_M_PWR | BIT_M_RSTN);
  endfunction

endpackage

// File: rtl/rxps_ms_tick.sv
module rxps_ms_tick #(
  parameter int CYC_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

  logic [PW-1:0] pre_q;

  assign tick = en && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/rxps_gap_timer.sv
module rxps_gap_timer #(
  parameter int GAP_MS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ms_tick,
  output logic expire
);
  localparam int MW = (GAP_MS > 1) ? $clog2(GAP_MS) : 1;
  localparam logic [MW-1:0] LAST = MW'(GAP_MS - 1);

  logic [MW-1:0] ms_q;

  assign expire = en && ms_tick && (ms_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || expire) ms_q <= '0;
    else if (ms_tick)         ms_q <= ms_q + 1'b1;
  end
endmodule

// File: rtl/rxps_seq_fsm.sv
module rxps_seq_fsm
  import rxps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] req_mode,
  input  logic       gap_expire,
  output logic       timer_en,
  output logic       busy,
  output logic       done,
  output lines_t     lines
);
  sq_state_t  st_q;
  logic [1:0] mode_q;
  lines_t     lines_q;

  assign busy     = (st_q == SQ_GAP1) || (st_q == SQ_GAP2) || (st_q == SQ_GAP3);
  assign done     = (st_q == SQ_FIN);
  assign timer_en = busy;
  assign lines    = lines_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      mode_q  <= MODE_MOBILE;
      lines_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          mode_q <= req_mode;
          if (req_mode == MODE_MOBILE || req_mode == MODE_TERR) begin
            lines_q <= lines_q & ~other_side(req_mode);
            st_q    <= SQ_GAP1;
          end else begin
            lines_q <= '0;
            st_q    <= SQ_FIN;
          end
        end
        SQ_GAP1: if (gap_expire) begin
          lines_q <= lines_q | own_pwr(mode_q);
          st_q    <= SQ_GAP2;
        end
        SQ_GAP2: if (gap_expire) begin
          lines_q <= lines_q | own_rstn(mode_q);
          st_q    <= SQ_GAP3;
        end
        SQ_GAP3: if (gap_expire) begin
          if (mode_q == MODE_TERR) lines_q <= lines_q | BIT_TSEL;
          else                     lines_q <= lines_q & ~BIT_TSEL;
          st_q <= SQ_FIN;
        end
        SQ_FIN:  st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_power_sequencer.sv
module rx_power_sequencer
  import rxps_pkg::*;
#(
  parameter int CLK_HZ  = 27000000,
  parameter int WAIT_MS = 50
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   req_mode,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [4:0]   ctl_lines
);
  localparam int CYC_RAW    = CLK_HZ / 1000;
  localparam int CYC_PER_MS = (CYC_RAW > 0) ? CYC_RAW : 1;

  logic   timer_en;
  logic   ms_tick;
  logic   gap_expire;
  lines_t lines;

  rxps_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (timer_en),
    .tick (ms_tick)
  );

  rxps_gap_timer #(.GAP_MS(WAIT_MS)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .en      (timer_en),
    .ms_tick (ms_tick),
    .expire  (gap_expire)
  );

  rxps_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .req_mode   (req_mode),
    .gap_expire (gap_expire),
    .timer_en   (timer_en),
    .busy       (busy),
    .done       (done),
    .lines      (lines)
  );

  assign ctl_lines = lines;
endmodule

// File: rtl/rxps_checker.sv
module rxps_checker #(
  parameter int CLK_HZ  = 27000000,
  parameter int WAIT_MS = 50
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [4:0] ctl_lines
);
  localparam int CYC_RAW = CLK_HZ / 1000;
  localparam int GAP_CYC = ((CYC_RAW > 0) ? CYC_RAW : 1) * WAIT_MS;

  logic [4:0] lines_q;
  logic       busy_q;
  int         gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      busy_q  <= 1'b0;
      gap_cnt <= 0;
    end else begin
      lines_q <= ctl_lines;
      busy_q  <= busy;
      if (!busy)                   gap_cnt <= 0;
      else if (ctl_lines != lines_q) gap_cnt <= 1;
      else                         gap_cnt <= gap_cnt + 1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctl_lines == 5'b0 && !busy && !done)); // R1

  AST_TERR_PWR_FIRST: assert property (@(posedge clk) disable iff (rst)
    ctl_lines[1] |-> ctl_lines[2]); // R6

  AST_MOB_PWR_FIRST: assert property (@(posedge clk) disable iff (rst)
    ctl_lines[3] |-> ctl_lines[4]); // R6

  AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ctl_lines != lines_q) |-> gap_cnt == GAP_CYC); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R8

  AST_IDLE_LINES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(ctl_lines)); // R9

  AST_BUSY_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done)); // R9
endmodule

bind rx_power_sequencer rxps_checker #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ctl_lines (ctl_lines)
);

// File: tb/sim_rx_power_sequencer.sv
module sim_rx_power_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4000;
  localparam int WAIT_MS    = 50;
  localparam int GAP        = (CLK_HZ / 1000) * WAIT_MS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req_mode = 2'b00;
  logic       start = 1'b0;
  logic       busy, done;
  logic [4:0] ctl_lines;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  rx_power_sequencer #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS)) u0 (
    .clk(clk), .rst(rst), .req_mode(req_mode), .start(start),
    .busy(busy), .done(done), .ctl_lines(ctl_lines)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: phase 0 idle, 1..3 waiting, 4 finished
  int         m_phase = 0;
  int         m_cnt = 0;
  int         m_mode = 0;
  logic [4:0] m_lines = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_phase <= 0;
      m_lines <= '0;
    end else if (m_phase == 0) begin
      if (start) begin
        m_mode <= req_mode;
        m_cnt  <= GAP;
        if (req_mode == 2'b01)      begin m_lines[2:1] <= 2'b00; m_phase <= 1; end
        else if (req_mode == 2'b10) begin m_lines[4:3] <= 2'b00; m_phase <= 1; end
        else                        begin m_lines <= '0;         m_phase <= 4; end
      end
    end else if (m_phase == 4) begin
      m_phase <= 0;
    end else if (m_cnt == 1) begin
      m_cnt   <= GAP;
      m_phase <= m_phase + 1;
      if (m_mode == 1) begin
        if (m_phase == 1) m_lines[4] <= 1'b1;
        if (m_phase == 2) m_lines[3] <= 1'b1;
        if (m_phase == 3) m_lines[0] <= 1'b0;
      end else begin
        if (m_phase == 1) m_lines[2] <= 1'b1;
        if (m_phase == 2) m_lines[1] <= 1'b1;
        if (m_phase == 3) m_lines[0] <= 1'b1;
      end
    end else begin
      m_cnt <= m_cnt - 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R3/R4 lines vs model", ctl_lines, m_lines);
      check("R8 busy vs model", busy, (m_phase >= 1 && m_phase <= 3));
      check("R8 done vs model", done, (m_phase == 4));
    end
  end

  task automatic strobe(input logic [1:0] m);
    @(negedge clk);
    req_mode = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Issue a request, report the lines after the first step, busy cycles and final lines
  task automatic run(input logic [1:0] m, output logic [4:0] first, output int nbusy,
                     output logic [4:0] final_l);
    strobe(m);
    first = ctl_lines;
    nbusy = 0;
    while (!done) begin
      if (busy) nbusy++;
      @(negedge clk);
    end
    final_l = ctl_lines;
    @(negedge clk);
  endtask

  initial begin
    logic [4:0] first, fin;
    int nb;
    int dpulses;

    repeat (3) @(negedge clk);
    check("R1 reset lines", ctl_lines, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 mobile from all-zero
    run(2'b01, first, nb, fin);
    check("R3 mobile first step", first, 5'b00000);
    check("R5 mobile busy length", nb, 3*GAP);
    check("R3 mobile final", fin, 5'b11000);

    // R4 terrestrial after mobile
    run(2'b10, first, nb, fin);
    check("R4 terrestrial first step", first, 5'b00000);
    check("R5 terrestrial busy length", nb, 3*GAP);
    check("R4 terrestrial final", fin, 5'b00111);

    // R10 mobile after terrestrial: select held until last step
    strobe(2'b01);
    check("R10 select held at first step", ctl_lines, 5'b00001);
    repeat (GAP) @(negedge clk);
    check("R10 select held after power-up", ctl_lines, 5'b10001);
    repeat (GAP) @(negedge clk);
    check("R10 select held after reset release", ctl_lines, 5'b11001);
    dpulses = 0;
    while (!done) @(negedge clk);
    check("R10 select cleared at end", ctl_lines, 5'b11000);
    @(negedge clk);

    // R7 standby with code 00
    run(2'b00, first, nb, fin);
    check("R7 standby 00 clears", first, 5'b00000);
    check("R7 standby 00 no busy", nb, 0);

    // R7 standby with code 11 after terrestrial
    run(2'b10, first, nb, fin);
    run(2'b11, first, nb, fin);
    check("R7 standby 11 clears", fin, 5'b00000);
    check("R7 standby 11 no busy", nb, 0);

    // R9 strobes during busy are ignored
    strobe(2'b01);
    repeat (GAP + 7) @(negedge clk);
    strobe(2'b10);
    repeat (GAP) @(negedge clk);
    strobe(2'b00);
    dpulses = 0;
    while (!done) @(negedge clk);
    check("R9 busy strobes ignored", ctl_lines, 5'b11000);
    @(negedge clk);
    check("R9 no restart after done", busy, 0);
    repeat (5) @(negedge clk);
    check("R9 lines hold in idle", ctl_lines, 5'b11000);

    // R1 reset mid-sequence
    strobe(2'b10);
    repeat (GAP + 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset lines", ctl_lines, 0);
    check("R1 mid-run reset busy", busy, 0);
    repeat (3) @(negedge clk);

    // R6 from reset, terrestrial: reset line never ahead of power
    strobe(2'b10);
    repeat (GAP) @(negedge clk);
    check("R6 power up before reset release", ctl_lines[2:1], 2'b10);
    repeat (GAP) @(negedge clk);
    check("R6 reset released after power", ctl_lines[2:1], 2'b11);
    while (!done) @(negedge clk);
    check("R2 terrestrial select bit 0", ctl_lines[0], 1);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule